// File: doc/BRIEF.md
# MDIO Management Master

This block is the serial master for a PHY management bus. Two registers drive it: a control register, which holds a 7-bit clock divisor and a bus select bit, and a command register. A write to the command register starts one clause-22 frame on the MDC clock and the MDIO data line. The frame is a read or a write to one register of one PHY. MDIO is presented as a split tri-state: a value, an output enable and an input.

While a frame is on the wire the block holds `busy` high. Software polls `busy` and waits for it to drop before it issues the next command. When a read frame ends, the 16 bits returned by the PHY appear on `rd_data`. The MDC period is a whole number of system clock cycles, set by the divisor. For example, a divisor of 26 on a 66 MHz clock gives roughly 2.5 MHz.

Top module: `mdio_master`

## Requirements
- R1: After reset, `busy` is 0, `mdc` is low, `mdio_oe` is 0 (MDIO released), `rd_data` is 0 and `bus_ext` is 0.
- R2: A `cmd_we` pulse while idle raises `busy` in the next cycle. `busy` then stays high for exactly 64*E cycles, where E is the effective divisor (the `cfg_div` value, with the exception given in R9).
- R3: Each MDC bit period lasts E cycles: first a low phase of E - floor(E/2) cycles, then a high phase of floor(E/2) cycles. MDC is low whenever `busy` is low.
- R4: The 64 frame bits go out most significant bit first, in this order: 32 ones, start code 01, opcode (10 for read, 01 for write), `cmd_phy[4:0]`, `cmd_reg[4:0]`, a 2-bit turnaround, then 16 data bits. `mdio_o` changes only when MDC falls.
- R5: In a write frame (`cmd_read`=0), `mdio_oe` is 1 for all 64 bits, the turnaround is driven as 10, and the data bits are `cmd_wdata`.
- R6: In a read frame, `mdio_oe` is 0 for bit positions 46..63, counted from 0 at the first preamble bit. `mdio_i` is sampled when MDC rises in each of bits 48..63. The 16 sampled bits, first sample as bit 15, replace `rd_data` in the same cycle that `busy` falls.
- R7: `rd_data` does not change during any frame, and it keeps its value across write frames.
- R8: A `cmd_we` pulse while `busy` is high is ignored. It neither alters the frame in progress nor starts another frame.
- R9: A divisor of 0 or 1 acts as 2, so MDC still toggles.
- R10: A `cfg_we` pulse loads `cfg_div` and `cfg_ext`. `bus_ext` shows the loaded select bit from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_div | input | 7 | MDC divisor (system cycles per MDC period) |
| cfg_ext | input | 1 | Bus select: 1 selects the external management bus |
| cmd_we | input | 1 | Command register write strobe; starts a frame when idle |
| cmd_read | input | 1 | 1 for a read frame, 0 for a write frame |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address within the PHY |
| cmd_wdata | input | 16 | Write data |
| busy | output | 1 | Frame in progress |
| rd_data | output | 16 | Data returned by the last read frame |
| bus_ext | output | 1 | Registered bus select bit |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
Every result has a fixed due time, counted from the clock edge that samples `cmd_we`:
- `busy` rises on that edge.
- The first MDC rise comes E - floor(E/2) cycles later.
- `busy` and the read result both change 64*E cycles later.

The bench drives inputs and samples outputs on falling clock edges, so each of these counts can be measured exactly. It records each MDIO bit and its enable at the falling clock edge that follows an MDC rise. A PHY responder presents read data in the same way, one bit period ahead of the sampling rise. The scoreboard compares the captured frame, the enable mask, the measured busy length, the low-phase length and `rd_data` in the cycle where `busy` has fallen.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [1:0] {
    MOP_WRITE = 2'b01,
    MOP_READ  = 2'b10
  } mdio_op_e;

  localparam int unsigned PREAMBLE_LEN = 32;
  localparam logic [1:0]  START_CODE   = 2'b01;
  localparam logic [1:0]  TA_WRITE     = 2'b10;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int unsigned DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic [DIV_W-1:0] eff, hi_len, lo_len;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;

  always_comb begin
    eff    = (div < DIV_W'(2)) ? DIV_W'(2) : div;
    hi_len = eff >> 1;
    lo_len = eff - hi_len;
  end

  always_comb begin
    cnt_d    = cnt_q;
    mdc_d    = mdc_q;
    rise_stb = 1'b0;
    fall_stb = 1'b0;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (!mdc_q) begin
      if (cnt_q == lo_len - DIV_W'(1)) begin
        rise_stb = 1'b1;
        mdc_d    = 1'b1;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_q + DIV_W'(1);
      end
    end else begin
      if (cnt_q == hi_len - DIV_W'(1)) begin
        fall_stb = 1'b1;
        mdc_d    = 1'b0;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc = mdc_q;
endmodule

// File: rtl/mdio_serializer.sv
module mdio_serializer
  import mdio_pkg::*;
#(
  parameter int unsigned PHY_W  = 5,
  parameter int unsigned REG_W  = 5,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_read,
  input  logic [PHY_W-1:0]  phy,
  input  logic [REG_W-1:0]  rg,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              mdio_i,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned FRAME_LEN = PREAMBLE_LEN + 6 + PHY_W + REG_W + DATA_W;
  localparam int unsigned IDX_W     = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(FRAME_LEN - DATA_W - 2);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(FRAME_LEN - DATA_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  logic                 busy_q, busy_d;
  logic                 rd_q, rd_d;
  logic [FRAME_LEN-1:0] sh_q, sh_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [DATA_W-1:0]    cap_q, cap_d;
  logic [DATA_W-1:0]    rdat_q, rdat_d;
  mdio_op_e             op;

  assign op = is_read ? MOP_READ : MOP_WRITE;

  always_comb begin
    busy_d = busy_q;
    rd_d   = rd_q;
    sh_d   = sh_q;
    idx_d  = idx_q;
    cap_d  = cap_q;
    rdat_d = rdat_q;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      rd_d   = is_read;
      idx_d  = '0;
      sh_d   = {{PREAMBLE_LEN{1'b1}}, START_CODE, op, phy, rg,
                (is_read ? 2'b00 : TA_WRITE),
                (is_read ? {DATA_W{1'b0}} : wdata)};
    end else if (busy_q) begin
      if (rise_stb && rd_q && idx_q >= DATA_IDX)
        cap_d = {cap_q[DATA_W-2:0], mdio_i};
      if (fall_stb) begin
        sh_d = sh_q << 1;
        if (idx_q == LAST_IDX) begin
          busy_d = 1'b0;
          if (rd_q) rdat_d = cap_q;
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      sh_q   <= '0;
      idx_q  <= '0;
      cap_q  <= '0;
      rdat_q <= '0;
    end else begin
      busy_q <= busy_d;
      rd_q   <= rd_d;
      sh_q   <= sh_d;
      idx_q  <= idx_d;
      cap_q  <= cap_d;
      rdat_q <= rdat_d;
    end
  end

  assign busy    = busy_q;
  assign mdio_o  = sh_q[FRAME_LEN-1];
  assign mdio_oe = busy_q && !(rd_q && idx_q >= TA_IDX);
  assign rd_data = rdat_q;

  a_r4_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !$stable(mdio_o)) |-> $past(fall_stb));
  a_r2_end_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(fall_stb));
  a_r7_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(rdat_q));
  a_r8_op_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> ($stable(rd_q) && $stable(idx_q) || $past(fall_stb)));
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int unsigned DIV_W  = 7,
  parameter int unsigned PHY_W  = 5,
  parameter int unsigned REG_W  = 5,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_ext,
  input  logic              cmd_we,
  input  logic              cmd_read,
  input  logic [PHY_W-1:0]  cmd_phy,
  input  logic [REG_W-1:0]  cmd_reg,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              busy,
  output logic [DATA_W-1:0] rd_data,
  output logic              bus_ext,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic [DIV_W-1:0] div_q, div_d;
  logic             ext_q, ext_d;
  logic             rise_stb, fall_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  always_comb begin
    div_d = div_q;
    ext_d = ext_q;
    if (cfg_we) begin
      div_d = cfg_div;
      ext_d = cfg_ext;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      div_q <= '0;
      ext_q <= 1'b0;
    end else begin
      div_q <= div_d;
      ext_q <= ext_d;
    end
  end

  assign bus_ext = ext_q;

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n_s), .run(busy), .div(div_q),
    .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mdio_serializer #(.PHY_W(PHY_W), .REG_W(REG_W), .DATA_W(DATA_W)) u_ser (
    .clk(clk), .rst_n(rst_n_s), .start(cmd_we), .is_read(cmd_read),
    .phy(cmd_phy), .rg(cmd_reg), .wdata(cmd_wdata),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_i(mdio_i),
    .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_data(rd_data)
  );

  a_r3_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n_s)
    !busy |-> !mdc);
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0({rise_stb, fall_stb}));
endmodule

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_ext, cmd_we, cmd_read, mdio_i;
  logic [6:0]  cfg_div;
  logic [4:0]  cmd_phy, cmd_reg;
  logic [15:0] cmd_wdata;
  logic        busy, bus_ext, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;

  always #2 clk = ~clk;

  mdio_master u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_div(cfg_div), .cfg_ext(cfg_ext),
    .cmd_we(cmd_we), .cmd_read(cmd_read), .cmd_phy(cmd_phy), .cmd_reg(cmd_reg),
    .cmd_wdata(cmd_wdata), .busy(busy), .rd_data(rd_data), .bus_ext(bus_ext),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  typedef struct {
    logic [63:0] frame;
    logic [63:0] oem;
    logic [15:0] rd;
    int          len;
    int          lo;
    bit          is_rd;
    bit          small_div;
    bit          ign;
  } exp_t;

  exp_t        q[$];
  int          checks = 0;
  int          errors = 0;
  int          cur_div = 0;
  logic [15:0] model_rd = 16'h0;
  logic [15:0] cur_rv = 16'h0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // scoreboard monitor
  logic        prev_busy = 1'b0, prev_mdc = 1'b0;
  logic [63:0] cap, capoe;
  int          nbit, cyc, first_lo;
  always @(negedge clk) begin
    if (busy && !prev_busy) begin
      nbit = 0; cyc = 0; cap = '0; capoe = '0; first_lo = -1;
    end
    if (busy) cyc++;
    if (mdc && !prev_mdc && nbit < 64) begin
      if (nbit == 0) first_lo = cyc - 1;
      cap[63-nbit]   = mdio_o;
      capoe[63-nbit] = mdio_oe;
      nbit++;
      if (nbit >= 48 && nbit < 64) mdio_i = cur_rv[63-nbit];
      else mdio_i = 1'b1;
    end
    if (!busy && prev_busy) begin
      if (q.size() == 0) begin
        chk("R8", "unexpected frame", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(e.ign ? "R8" : "R4", "frame bits", cap & e.oem, e.frame & e.oem);
        chk(e.is_rd ? "R6" : "R5", "oe mask", capoe, e.oem);
        chk(e.small_div ? "R9" : "R2", "busy length", 64'(cyc), 64'(e.len));
        chk("R3", "low phase", 64'(first_lo), 64'(e.lo));
        chk(e.is_rd ? "R6" : "R7", "rd_data", 64'(rd_data), 64'(e.rd));
      end
    end
    prev_busy = busy;
    prev_mdc  = mdc;
  end

  task automatic set_cfg(int dv, logic ext);
    @(negedge clk);
    cfg_we = 1'b1; cfg_div = 7'(dv); cfg_ext = ext;
    @(negedge clk);
    cfg_we = 1'b0;
    cur_div = dv;
    chk("R10", "bus_ext", 64'(bus_ext), 64'(ext));
  endtask

  task automatic push_cmd(bit rd, logic [4:0] phy, logic [4:0] rg,
                          logic [15:0] wd, logic [15:0] rv, bit ign);
    exp_t e;
    int   ef;
    ef = (cur_div < 2) ? 2 : cur_div;
    e.frame = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg,
               (rd ? 2'b00 : 2'b10), (rd ? 16'h0 : wd)};
    e.oem   = rd ? {{46{1'b1}}, {18{1'b0}}} : {64{1'b1}};
    if (rd) model_rd = rv;
    e.rd        = model_rd;
    e.len       = 64 * ef;
    e.lo        = ef - ef / 2;
    e.is_rd     = rd;
    e.small_div = (cur_div < 2);
    e.ign       = ign;
    q.push_back(e);
    cur_rv = rv;
    @(negedge clk);
    cmd_we = 1'b1; cmd_read = rd; cmd_phy = phy; cmd_reg = rg; cmd_wdata = wd;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic wait_done();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(negedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 0; cfg_div = 0; cfg_ext = 0; cmd_we = 0;
    cmd_read = 0; cmd_phy = 0; cmd_reg = 0; cmd_wdata = 0; mdio_i = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "busy", 64'(busy), 64'd0);
    chk("R1", "mdc", 64'(mdc), 64'd0);
    chk("R1", "mdio_oe", 64'(mdio_oe), 64'd0);
    chk("R1", "rd_data", 64'(rd_data), 64'd0);
    chk("R1", "bus_ext", 64'(bus_ext), 64'd0);

    set_cfg(2, 1'b0);
    push_cmd(1'b0, 5'h05, 5'h1A, 16'hBEEF, 16'h0, 1'b0); wait_done();
    push_cmd(1'b1, 5'h1F, 5'h02, 16'h0, 16'h1234, 1'b0); wait_done();
    set_cfg(0, 1'b1);   // R9 divisor 0
    push_cmd(1'b0, 5'h00, 5'h1F, 16'h0001, 16'h0, 1'b0); wait_done();
    set_cfg(1, 1'b0);   // R9 divisor 1
    push_cmd(1'b1, 5'h0A, 5'h15, 16'h0, 16'hA5C3, 1'b0); wait_done();
    set_cfg(5, 1'b1);
    // R8: command during a frame is ignored
    push_cmd(1'b0, 5'h11, 5'h0C, 16'h8421, 16'h0, 1'b1);
    repeat (40) @(negedge clk);
    cmd_we = 1'b1; cmd_read = 1'b1; cmd_phy = 5'h03; cmd_reg = 5'h07;
    @(negedge clk);
    cmd_we = 1'b0;
    wait_done();
    begin
      int seen = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (busy) seen++;
      end
      chk("R8", "no second frame", 64'(seen), 64'd0);
    end
    push_cmd(1'b1, 5'h01, 5'h00, 16'h0, 16'h8001, 1'b0); wait_done();
    set_cfg(3, 1'b0);
    push_cmd(1'b0, 5'h1E, 5'h01, 16'h7FFE, 16'h0, 1'b0); wait_done();
    chk("R3", "mdc idle", 64'(mdc), 64'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule